// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits between a bank of latched interrupt request flags and a small CPU sequencer. At an instruction boundary, while the global interrupt enable is set, it looks at every pending and enabled source. The source with the lowest vector index wins. The block then runs the entry sequence: it clears the global enable, pushes the two-byte return address to an external stack, issues the vector address, and sends an acknowledge to the winner. It also runs the return sequence, which pops the two bytes, hands the address back and sets the global enable again.

Vectors are two words apart. The table starts at zero, or at a boot-section base when the vector-select bit is set. That bit is protected: it can only change inside a short window that a separate arm write opens. The reset address comes from its own configuration pin. The vector, acknowledge, stack and resume outputs are single-cycle pulses timed by the block. The sequencer and the stack stub must take them in the cycle they appear, and there is no back-pressure on any of them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector address is base + 2×(k+1) for source bit k. The base is 0x0000 when the vector-select bit is 0, so bit 0 gives 0x0002. The base is BOOT_BASE (0x3800) when the select bit is 1, so bit 24 gives 0x3832.
- R2: When several sources are pending and enabled, the one with the lowest bit number wins.
- R3: No source is accepted while the global enable is 0. A source whose enable bit is 0 never wins. Neither case acknowledges the source, so its flag stays pending.
- R4: Accepting an interrupt clears the global enable from the next cycle onward.
- R5: After the accept edge, the vector and its acknowledge appear in cycle 4. If the CPU was sleeping when the interrupt was accepted, they appear in cycle 8. The stack receives return-address bit 7..0 one cycle before the vector, and bit 15..8 in the vector's own cycle.
- R6: A return lasts four cycles. It pops bits 15..8 first and then bits 7..0, which returns the stack pointer to where it was before entry. In cycle 4 it presents the resume address, and the global enable is 1 from the next cycle.
- R7: After a return, the first instruction boundary never accepts an interrupt. The next boundary may accept one.
- R8: The acknowledge is one-hot on the winning source's bit in the vector cycle, and zero in every other cycle.
- R9: A control write with bit 0 = 1 opens a change window and leaves the select unchanged. A write with bit 0 = 0 loads bit 1 into the select only if it lands within the four cycles after the arm write, and that write closes the window. At any other time the select ignores writes.
- R10: The reset address is BOOT_BASE when boot_reset_sel is 1, and 0x0000 otherwise.
- R11: While no sequence runs, a software write sets or clears the global enable. Setting it inside a handler lets a nested interrupt enter.
- R12: After reset, the global enable and the vector-select bit are 0, no sequence is busy, and no vector or acknowledge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_reset_sel | input | 1 | Configuration pin that selects the boot-section reset address |
| reset_addr | output | 16 | Reset address |
| req_pending | input | NUM_SRC | Latched request flags; bit k uses vector index k+1 |
| src_en | input | NUM_SRC | Enable bit for each source |
| insn_boundary | input | 1 | The current instruction has completed |
| sleeping | input | 1 | The CPU is asleep; treated as a boundary, with a longer entry |
| reti_req | input | 1 | A return-from-interrupt has executed |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wr_val | input | 1 | Value written to the global enable |
| ctl_wr | input | 1 | Write strobe for the vector-control register |
| ctl_wdata | input | 2 | Bit 1 is the select value, bit 0 is the arm bit |
| ret_pc | input | 16 | Return address to save on entry |
| stk_rdata | input | 8 | Byte at stack pointer + 1 |
| gie | output | 1 | Global interrupt enable |
| vsel | output | 1 | Vector-select bit |
| vsel_open | output | 1 | Change window is open |
| busy | output | 1 | An entry or return sequence is running |
| vec_valid | output | 1 | Vector-issue pulse |
| vec_addr | output | 16 | Vector address, valid with vec_valid |
| src_ack | output | NUM_SRC | Acknowledge to the winning source |
| stk_push | output | 1 | Push stk_wdata and decrement the stack pointer |
| stk_pop | output | 1 | Pop and increment the stack pointer |
| stk_wdata | output | 8 | Byte to push |
| resume_valid | output | 1 | Return-address pulse |
| resume_pc | output | 16 | Popped return address |

## Verification
The bench opens the change window and makes the select write on the last legal cycle, then again one cycle late. A design with an off-by-one window counter would either drop the first write or accept the second. It makes a second write after the window has already been closed, which catches a window that stays open once it has been used. It drives a boundary immediately after a return while an eligible source is pending; a controller without the post-return hold would enter at once. It also runs a nested entry, a sleeping entry with the longer latency, and a winner chosen over a lower, disabled source. A wrong priority chain, a wrong count or pushes in the wrong byte order each show up as a wrong vector, a wrong latency or a wrong resume address.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef logic [15:0] addr_t;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ENTER, SEQ_RETURN} seq_state_e;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_SRC = 25,
  localparam int IW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  output logic               any,
  output logic [IW-1:0]      idx
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = pend[g] & en[g];
  end

  // lowest bit number has the highest priority
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end

  assign any = |elig;
endmodule

// File: rtl/irq_vbase_reg.sv
module irq_vbase_reg #(
  parameter int WIN = 4,
  localparam int CW = $clog2(WIN)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       sel,
  output logic       open
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      open <= 1'b0;
      cnt  <= '0;
    end else if (wr && wdata[0]) begin
      open <= 1'b1;
      cnt  <= CW'(WIN - 1);
    end else if (wr && open) begin
      sel  <= wdata[1];
      open <= 1'b0;
    end else if (open) begin
      if (cnt == '0) open <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC     = 25,
  parameter int ENT_CYC     = 4,
  parameter int SLEEP_EXTRA = 4,
  parameter int RET_CYC     = 4,
  localparam int IW = $clog2(NUM_SRC),
  localparam int MAXC = (ENT_CYC + SLEEP_EXTRA > RET_CYC) ? ENT_CYC + SLEEP_EXTRA : RET_CYC,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_elig,
  input  logic [IW-1:0]      win_idx,
  input  logic               insn_boundary,
  input  logic               sleeping,
  input  logic               reti_req,
  input  logic               gie_wr,
  input  logic               gie_wr_val,
  input  addr_t              ret_pc,
  input  logic [7:0]         stk_rdata,
  output logic               gie,
  output logic               busy,
  output logic               vec_valid,
  output logic [IW-1:0]      cur_idx,
  output logic [NUM_SRC-1:0] src_ack,
  output logic               stk_push,
  output logic               stk_pop,
  output logic [7:0]         stk_wdata,
  output logic               resume_valid,
  output addr_t              resume_pc
);
  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          hold;
  addr_t         pc_q;
  logic [7:0]    hi_q, lo_q;
  logic          at_bound, take;

  assign at_bound = insn_boundary | sleeping;
  assign take     = at_bound & gie & any_elig & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      gie     <= 1'b0;
      hold    <= 1'b0;
      pc_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cur_idx <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (reti_req) begin
            state <= SEQ_RETURN;
            cnt   <= CW'(RET_CYC - 1);
          end else if (take) begin
            state   <= SEQ_ENTER;
            cnt     <= sleeping ? CW'(ENT_CYC + SLEEP_EXTRA - 1) : CW'(ENT_CYC - 1);
            gie     <= 1'b0;
            cur_idx <= win_idx;
            pc_q    <= ret_pc;
          end else begin
            if (gie_wr) gie <= gie_wr_val;
            if (hold && at_bound) hold <= 1'b0;
          end
        end
        SEQ_ENTER: begin
          if (cnt == '0) state <= SEQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        SEQ_RETURN: begin
          if (cnt == CW'(RET_CYC - 1)) hi_q <= stk_rdata;
          if (cnt == CW'(RET_CYC - 2)) lo_q <= stk_rdata;
          if (cnt == '0) begin
            state <= SEQ_IDLE;
            gie   <= 1'b1;
            hold  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy         = (state != SEQ_IDLE);
  assign vec_valid    = (state == SEQ_ENTER) && (cnt == '0);
  assign src_ack      = vec_valid ? (NUM_SRC'(1) << cur_idx) : '0;
  assign stk_push     = (state == SEQ_ENTER) && (cnt <= CW'(1));
  assign stk_wdata    = (cnt == CW'(1)) ? pc_q[7:0] : pc_q[15:8];
  assign stk_pop      = (state == SEQ_RETURN) &&
                        ((cnt == CW'(RET_CYC - 1)) || (cnt == CW'(RET_CYC - 2)));
  assign resume_valid = (state == SEQ_RETURN) && (cnt == '0);
  assign resume_pc    = {hi_q, lo_q};
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int    NUM_SRC     = 25,
  parameter addr_t BOOT_BASE   = 16'h3800,
  parameter int    ENT_CYC     = 4,
  parameter int    SLEEP_EXTRA = 4,
  parameter int    RET_CYC     = 4,
  parameter int    WIN         = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_reset_sel,
  output logic [15:0]        reset_addr,
  input  logic [NUM_SRC-1:0] req_pending,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               insn_boundary,
  input  logic               sleeping,
  input  logic               reti_req,
  input  logic               gie_wr,
  input  logic               gie_wr_val,
  input  logic               ctl_wr,
  input  logic [1:0]         ctl_wdata,
  input  logic [15:0]        ret_pc,
  input  logic [7:0]         stk_rdata,
  output logic               gie,
  output logic               vsel,
  output logic               vsel_open,
  output logic               busy,
  output logic               vec_valid,
  output logic [15:0]        vec_addr,
  output logic [NUM_SRC-1:0] src_ack,
  output logic               stk_push,
  output logic               stk_pop,
  output logic [7:0]         stk_wdata,
  output logic               resume_valid,
  output logic [15:0]        resume_pc
);
  localparam int IW = $clog2(NUM_SRC);

  logic          any_elig;
  logic [IW-1:0] win_idx, cur_idx;
  addr_t         base;

  irq_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend (req_pending),
    .en   (src_en),
    .any  (any_elig),
    .idx  (win_idx)
  );

  irq_vbase_reg #(.WIN(WIN)) u_vbase (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .sel   (vsel),
    .open  (vsel_open)
  );

  irq_seq #(
    .NUM_SRC(NUM_SRC), .ENT_CYC(ENT_CYC),
    .SLEEP_EXTRA(SLEEP_EXTRA), .RET_CYC(RET_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .any_elig      (any_elig),
    .win_idx       (win_idx),
    .insn_boundary (insn_boundary),
    .sleeping      (sleeping),
    .reti_req      (reti_req),
    .gie_wr        (gie_wr),
    .gie_wr_val    (gie_wr_val),
    .ret_pc        (ret_pc),
    .stk_rdata     (stk_rdata),
    .gie           (gie),
    .busy          (busy),
    .vec_valid     (vec_valid),
    .cur_idx       (cur_idx),
    .src_ack       (src_ack),
    .stk_push      (stk_push),
    .stk_pop       (stk_pop),
    .stk_wdata     (stk_wdata),
    .resume_valid  (resume_valid),
    .resume_pc     (resume_pc)
  );

  assign base       = vsel ? BOOT_BASE : addr_t'(0);
  assign vec_addr   = base + ((addr_t'(cur_idx) + addr_t'(1)) << 1);
  assign reset_addr = boot_reset_sel ? BOOT_BASE : addr_t'(0);
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gie,
  input logic               vsel,
  input logic               vsel_open,
  input logic               vec_valid,
  input logic [NUM_SRC-1:0] src_ack,
  input logic [NUM_SRC-1:0] src_en,
  input logic               stk_push,
  input logic               stk_pop,
  input logic               resume_valid
);
  p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $countones(src_ack) == 1);

  p_ack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> src_ack == '0);

  p_ack_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (src_ack & src_en) != '0);

  p_gie_low_on_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !gie);

  p_gie_after_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> gie);

  p_push_pop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));

  p_vsel_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsel) |-> $past(vsel_open));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gie          (gie),
  .vsel         (vsel),
  .vsel_open    (vsel_open),
  .vec_valid    (vec_valid),
  .src_ack      (src_ack),
  .src_en       (src_en),
  .stk_push     (stk_push),
  .stk_pop      (stk_pop),
  .resume_valid (resume_valid)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int N = 25;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         boot_reset_sel = 1'b0;
  logic [15:0]  reset_addr;
  logic [N-1:0] req_pending = '0;
  logic [N-1:0] src_en = '0;
  logic         insn_boundary = 1'b0, sleeping = 1'b0, reti_req = 1'b0;
  logic         gie_wr = 1'b0, gie_wr_val = 1'b0;
  logic         ctl_wr = 1'b0;
  logic [1:0]   ctl_wdata = '0;
  logic [15:0]  ret_pc = '0;
  logic [7:0]   stk_rdata;
  logic         gie, vsel, vsel_open, busy, vec_valid;
  logic [15:0]  vec_addr;
  logic [N-1:0] src_ack;
  logic         stk_push, stk_pop;
  logic [7:0]   stk_wdata;
  logic         resume_valid;
  logic [15:0]  resume_pc;

  always #5 clk = ~clk;

  irq_vector_ctrl uut (.*);

  // stack stub
  logic [7:0] sp = 8'hFF;
  logic [7:0] smem [256];
  assign stk_rdata = smem[sp + 8'd1];
  always @(posedge clk) begin
    if (stk_push) begin smem[sp] <= stk_wdata; sp <= sp - 8'd1; end
    if (stk_pop)  sp <= sp + 8'd1;
  end

  // source stub: ack clears the flag
  always @(posedge clk) if (src_ack != '0) req_pending <= req_pending & ~src_ack;

  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0] exp_vec_q [$];
  int          exp_idx_q [$];
  logic [15:0] exp_res_q [$];

  always @(negedge clk) if (rst_n) begin
    if (vec_valid) begin
      if (exp_vec_q.size() == 0) chk(0, "R3", "unexpected vector", vec_addr, 0);
      else begin
        logic [15:0] ea; int ei;
        ea = exp_vec_q.pop_front(); ei = exp_idx_q.pop_front();
        chk(vec_addr == ea, "R1", "vector address", vec_addr, ea);
        chk(src_ack == (N'(1) << ei), "R8", "acknowledge", src_ack, N'(1) << ei);
      end
    end
    if (resume_valid) begin
      if (exp_res_q.size() == 0) chk(0, "R6", "unexpected resume", resume_pc, 0);
      else begin
        logic [15:0] er;
        er = exp_res_q.pop_front();
        chk(resume_pc == er, "R6", "resume address", resume_pc, er);
      end
    end
  end

  // drive an accept and count cycles to the vector
  task automatic enter(input int idx, input logic [15:0] base, input bit slp,
                       input logic [15:0] pc, input string req);
    int n;
    exp_vec_q.push_back(base + 16'((idx + 1) * 2));
    exp_idx_q.push_back(idx);
    ret_pc = pc;
    if (slp) sleeping = 1'b1; else insn_boundary = 1'b1;
    @(negedge clk);
    sleeping = 1'b0; insn_boundary = 1'b0;
    chk(busy == 1'b1, req, "busy after accept", busy, 1);
    chk(gie == 1'b0, "R4", "gie cleared on accept", gie, 0);
    n = 1;
    while (!vec_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == (slp ? 8 : 4), "R5", "entry latency", n, slp ? 8 : 4);
    @(negedge clk);
  endtask

  task automatic leave(input logic [15:0] pc);
    int n;
    exp_res_q.push_back(pc);
    reti_req = 1'b1;
    @(negedge clk);
    reti_req = 1'b0;
    n = 1;
    while (!resume_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 4, "R6", "return latency", n, 4);
    @(negedge clk);
    chk(gie == 1'b1, "R6", "gie set after return", gie, 1);
  endtask

  task automatic set_gie(input bit v);
    gie_wr = 1'b1; gie_wr_val = v;
    @(negedge clk);
    gie_wr = 1'b0;
  endtask

  task automatic ctl(input logic [1:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(gie == 0 && vsel == 0 && busy == 0 && vec_valid == 0 && src_ack == 0,
        "R12", "reset state", {gie, vsel, busy, vec_valid}, 0);
    // R10 reset address
    chk(reset_addr == 16'h0000, "R10", "reset addr sel=0", reset_addr, 0);
    boot_reset_sel = 1'b1; #1;
    chk(reset_addr == 16'h3800, "R10", "reset addr sel=1", reset_addr, 16'h3800);

    // R3 gie low blocks acceptance
    src_en = '1;
    req_pending = N'(1) << 2;
    insn_boundary = 1'b1;
    repeat (3) @(negedge clk);
    insn_boundary = 1'b0;
    chk(busy == 0 && req_pending[2], "R3", "no accept with gie=0", busy, 0);

    // R11 software enable, R2 priority among 2,7,9
    set_gie(1'b1);
    chk(gie == 1, "R11", "gie written", gie, 1);
    req_pending = (N'(1) << 7) | (N'(1) << 2) | (N'(1) << 9);
    enter(2, 16'h0000, 1'b0, 16'h1234, "R2");
    chk(req_pending == ((N'(1) << 7) | (N'(1) << 9)), "R2", "only winner acked",
        req_pending, (N'(1) << 7) | (N'(1) << 9));
    // R5 push order: low byte first at 0xFF, high at 0xFE
    chk(sp == 8'hFD && smem[8'hFF] == 8'h34 && smem[8'hFE] == 8'h12, "R5",
        "pushed bytes", {sp, smem[8'hFF], smem[8'hFE]}, 24'hFD3412);

    // R11 nesting: enable inside the handler, next winner is bit 7
    set_gie(1'b1);
    enter(7, 16'h0000, 1'b0, 16'hBEEF, "R11");
    chk(sp == 8'hFB, "R11", "nested push depth", sp, 8'hFB);

    leave(16'hBEEF);
    // R7 hold: bit 9 eligible, first boundary must not accept
    exp_vec_q.push_back(16'h0014); exp_idx_q.push_back(9);
    ret_pc = 16'h0777;
    insn_boundary = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R7", "no accept on first boundary", busy, 0);
    @(negedge clk);
    insn_boundary = 1'b0;
    chk(busy == 1, "R7", "accept on second boundary", busy, 1);
    repeat (4) @(negedge clk);
    leave(16'h0777);
    leave(16'h1234);
    chk(sp == 8'hFF, "R6", "stack pointer restored", sp, 8'hFF);

    // R3 disabled lower source loses to enabled bit 5
    src_en = ~(N'(1) << 0);
    req_pending = (N'(1) << 0) | (N'(1) << 5);
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0; // clears hold
    enter(5, 16'h0000, 1'b0, 16'h0100, "R3");
    chk(req_pending[0] == 1'b1, "R3", "disabled flag still pending", req_pending[0], 1);
    leave(16'h0100);
    req_pending = '0;

    // R5 sleeping entry
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0;
    src_en = '1;
    req_pending = N'(1) << 3;
    enter(3, 16'h0000, 1'b1, 16'h0200, "R5");
    leave(16'h0200);

    // R9 late select write ignored
    ctl(2'b01);
    chk(vsel_open == 1, "R9", "window opens", vsel_open, 1);
    repeat (4) @(negedge clk);
    chk(vsel_open == 0, "R9", "window expired", vsel_open, 0);
    ctl(2'b10);
    chk(vsel == 0, "R9", "late write ignored", vsel, 0);

    // R9 write on last legal cycle accepted, window closes
    ctl(2'b01);
    repeat (3) @(negedge clk);
    ctl(2'b10);
    chk(vsel == 1 && vsel_open == 0, "R9", "write in window", {vsel, vsel_open}, 2'b10);
    ctl(2'b00);
    chk(vsel == 1, "R9", "write after close ignored", vsel, 1);

    // R1 relocated base with the last source
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0;
    req_pending = N'(1) << 24;
    enter(24, 16'h3800, 1'b0, 16'h0300, "R1");
    leave(16'h0300);

    // R1 first source at unrelocated base
    ctl(2'b01); ctl(2'b00);
    chk(vsel == 0, "R9", "select cleared", vsel, 0);
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0;
    req_pending = N'(1) << 0;
    enter(0, 16'h0000, 1'b0, 16'h0400, "R1");
    leave(16'h0400);

    repeat (3) @(negedge clk);
    chk(exp_vec_q.size() == 0 && exp_res_q.size() == 0, "R8", "scoreboard drained",
        exp_vec_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule